// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block is a bus master for external memory or I/O on a two-strobe bus. The low address byte and the data byte share one set of eight lines. An internal core hands it one request at a time: a 12-bit address, a read or write flag, a data-space flag and, for writes, a byte. The block then drives a fixed sequence of phases. Each phase lasts a whole number of system clocks:

- address setup on the shared lines;
- address strobe low, with the external side latching the address as the strobe rises;
- release of the shared lines;
- data strobe low;
- recovery.

Read data is taken from the shared lines at the rising edge of the data strobe. It is returned to the core with a one-clock completion pulse. An extended-timing input, sampled with each request, stretches the data strobe by two clocks. This suits slow devices.

Top module: `mux_bus_ctrl`

## Requirements
- R1: During an access, the upper 4 address bits appear on `bus_hi` while the address strobe is low. They are held through the completion pulse.
- R2: The shared lines are driven with address bits 7..0 during setup and while `as_n` is low. They are still driven in the last cycle before `as_n` rises.
- R3: `rd_wr_n` (1 = read, 0 = write) matches the request from the first cycle of the access until after `ds_n` has risen.
- R4: In the clock after `as_n` rises, the shared lines are released (`ad_oe` = 0). On a read they stay released while `ds_n` is low, so `ds_n` never falls while the address is on the lines.
- R5: On a write, the write byte is driven on the shared lines in the clock before `ds_n` falls, and stays driven while `ds_n` is low.
- R6: On a read, the byte present on `ad_in` when `ds_n` rises is returned on `rdata` while `done` is high.
- R7: `ds_n` is low for `T_DS` clocks, or `T_DS`+2 when `ext_mode` was 1 with the request. With the default parameters an access takes 7 clocks from acceptance to `done`, or 9 in extended mode.
- R8: `dm_n` equals the inverse of `req_dm` when `as_n` falls, and stays so for the whole access. It is 1 when idle.
- R9: A request is accepted only while `req_ready` is 1. `req_valid` raised during an access starts no extra access.
- R10: `done` is high for exactly one clock per access.
- R11: When idle, and in the clock after a synchronous reset (even in the middle of an access), `as_n` = `ds_n` = 1, `ad_oe` = 0 and `req_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dm | input | 1 | 1 = data-memory space |
| ext_mode | input | 1 | 1 = extended timing for this request |
| req_addr | input | 12 | Access address |
| req_wdata | input | 8 | Write byte |
| done | output | 1 | One-clock end-of-access pulse |
| rdata | output | 8 | Captured read byte |
| bus_hi | output | 4 | Upper address lines |
| ad_out | output | 8 | Shared lines, outgoing value |
| ad_oe | output | 1 | Shared lines output enable |
| ad_in | input | 8 | Shared lines, incoming value |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rd_wr_n | output | 1 | 1 = read, 0 = write |
| dm_n | output | 1 | Data-memory select, active low |

## Verification
The bench keeps the default phase lengths: one clock each for setup, address strobe, release, write-data lead and recovery, and two for the data strobe. With these settings every strobe edge and phase boundary falls on a known clock. The 7- and 9-clock access lengths can be checked exactly. A small external memory model latches the address on the strobe edge and answers reads, so written bytes, including 00 and FF, are seen coming back. Extended and normal accesses are interleaved, a mid-access reset is applied, and requests are raised while the controller is busy.

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl #(
  parameter int AW      = 12,
  parameter int DW      = 8,
  parameter int T_SETUP = 1,
  parameter int T_AS    = 1,
  parameter int T_FLOAT = 1,
  parameter int T_WLEAD = 1,
  parameter int T_DS    = 2,
  parameter int T_REC   = 1,
  parameter int T_EXT   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_dm,
  input  logic          ext_mode,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-DW-1:0] bus_hi,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic          as_n,
  output logic          ds_n,
  output logic          rd_wr_n,
  output logic          dm_n
);
  localparam int CW = $clog2(T_SETUP + T_AS + T_FLOAT + T_WLEAD + T_DS + T_EXT + T_REC + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_ASL, S_FLOAT, S_WLEAD, S_DSL, S_REC} st_t;

  st_t           st, nxt;
  logic [CW-1:0] cnt, nxt_len;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          wr_q, dm_q, ext_q;

  always_comb begin
    nxt     = S_IDLE;
    nxt_len = '0;
    case (st)
      S_SETUP: begin nxt = S_ASL;   nxt_len = CW'(T_AS - 1);    end
      S_ASL:   begin nxt = S_FLOAT; nxt_len = CW'(T_FLOAT - 1); end
      S_FLOAT: begin nxt = S_WLEAD; nxt_len = CW'(T_WLEAD - 1); end
      S_WLEAD: begin nxt = S_DSL;   nxt_len = ext_q ? CW'(T_DS + T_EXT - 1) : CW'(T_DS - 1); end
      S_DSL:   begin nxt = S_REC;   nxt_len = CW'(T_REC - 1);   end
      default: begin nxt = S_IDLE;  nxt_len = '0;               end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      dm_q    <= 1'b0;
      ext_q   <= 1'b0;
      rdata   <= '0;
    end else if (st == S_IDLE) begin
      if (req_valid) begin
        st      <= S_SETUP;
        cnt     <= CW'(T_SETUP - 1);
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        wr_q    <= req_write;
        dm_q    <= req_dm;
        ext_q   <= ext_mode;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      st  <= nxt;
      cnt <= nxt_len;
      if (st == S_DSL && !wr_q) rdata <= ad_in;
    end
  end

  wire addr_ph = (st == S_SETUP) || (st == S_ASL);
  wire data_ph = (st == S_WLEAD) || (st == S_DSL) || (st == S_REC);

  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_REC) && (cnt == '0);
  assign as_n      = (st != S_ASL);
  assign ds_n      = (st != S_DSL);
  assign ad_oe     = addr_ph || (wr_q && data_ph);
  assign ad_out    = addr_ph ? addr_q[DW-1:0] : wdata_q;
  assign bus_hi    = addr_q[AW-1:DW];
  assign rd_wr_n   = (st == S_IDLE) ? 1'b1 : !wr_q;
  assign dm_n      = (st == S_IDLE) ? 1'b1 : !dm_q;

  a_r2_addr_at_as_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(as_n) |-> $past(ad_oe) && ($past(ad_out) == addr_q[DW-1:0]));
  a_r4_float_after_as: assert property (@(posedge clk) disable iff (rst)
    $rose(as_n) |-> !ad_oe);
  a_r4_no_addr_under_ds: assert property (@(posedge clk) disable iff (rst)
    (!ds_n && rd_wr_n) |-> !ad_oe);
  a_r3_rw_stable: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !$past(req_ready)) |-> $stable(rd_wr_n));
  a_r8_dm_stable: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !$past(req_ready)) |-> $stable(dm_n));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (as_n && ds_n && !ad_oe));
  a_r4_strobes_apart: assert property (@(posedge clk) disable iff (rst)
    !(!as_n && !ds_n));
endmodule

// File: tb/tb_mux_bus_ctrl.sv
module tb_mux_bus_ctrl;
  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, req_dm = 0, ext_mode = 0;
  logic [11:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, done, ad_oe, as_n, ds_n, rd_wr_n, dm_n;
  logic [7:0] rdata, ad_out, ad_in;
  logic [3:0] bus_hi;

  always #10 clk = ~clk;

  mux_bus_ctrl dut (.clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_dm(req_dm), .ext_mode(ext_mode), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .bus_hi(bus_hi), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .as_n(as_n), .ds_n(ds_n), .rd_wr_n(rd_wr_n), .dm_n(dm_n));

  typedef struct { logic wr; logic dm; logic ext; logic [11:0] addr; logic [7:0] data; } item_t;
  item_t q[$];

  int checks = 0, fails = 0, issued = 0, started = 0;
  logic [7:0] ext_mem [256];
  logic [7:0] ref_mem [256];
  logic [11:0] lat_addr = '0;
  logic mute = 0;

  function automatic logic [7:0] hidx(logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]};
  endfunction

  assign ad_in = ext_mem[hidx(lat_addr)];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(bit wr, bit dm, bit ext, logic [11:0] a, logic [7:0] d);
    item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    it.wr = wr; it.dm = dm; it.ext = ext; it.addr = a;
    it.data = wr ? d : ref_mem[hidx(a)];
    if (wr) ref_mem[hidx(a)] = d;
    q.push_back(it);
    issued++;
    req_valid = 1; req_write = wr; req_dm = dm; ext_mode = ext; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  logic prev_as = 1, prev_ds = 1, prev_oe = 0;
  logic [7:0] last_ad = '0, last_ds_ad = '0;
  logic last_oe = 0;
  int busy_cyc = 0, ds_cyc = 0;

  always @(negedge clk) begin
    if (rst || mute) begin
      prev_as = 1; prev_ds = 1; prev_oe = 0; busy_cyc = 0; ds_cyc = 0;
    end else begin
      if (!req_ready) busy_cyc++;
      if (req_ready) chk(as_n && ds_n && !ad_oe && !done, "R11 idle lines", {as_n, ds_n, ad_oe}, 3'b110);
      if (!as_n && prev_as) begin
        started++;
        if (q.size() > 0) begin
          chk(dm_n == !q[0].dm, "R8 dm_n at AS fall", dm_n, !q[0].dm);
          chk(bus_hi == q[0].addr[11:8], "R1 upper address", bus_hi, q[0].addr[11:8]);
          chk(rd_wr_n == !q[0].wr, "R3 rd_wr_n at AS fall", rd_wr_n, !q[0].wr);
        end
      end
      if (!as_n) begin last_ad = ad_out; last_oe = ad_oe; end
      if (as_n && !prev_as && q.size() > 0) begin
        chk(last_oe && last_ad == q[0].addr[7:0], "R2 address at AS rise", last_ad, q[0].addr[7:0]);
        chk(!ad_oe, "R4 lines float after AS rise", ad_oe, 0);
        lat_addr = {bus_hi, last_ad};
      end
      if (!ds_n && prev_ds && q.size() > 0) begin
        if (q[0].wr)
          chk(prev_oe && ad_oe && ad_out == q[0].data, "R5 write data lead", ad_out, q[0].data);
        else
          chk(!ad_oe, "R4 no drive under DS on read", ad_oe, 0);
      end
      if (!ds_n) begin ds_cyc++; last_ds_ad = ad_out; end
      if (ds_n && !prev_ds && q.size() > 0) begin
        chk(ds_cyc == (q[0].ext ? 4 : 2), "R7 DS low width", ds_cyc, q[0].ext ? 4 : 2);
        chk(rd_wr_n == !q[0].wr, "R3 rd_wr_n after DS rise", rd_wr_n, !q[0].wr);
        if (q[0].wr) ext_mem[hidx(lat_addr)] = last_ds_ad;
        ds_cyc = 0;
      end
      if (done) begin
        if (q.size() == 0) chk(0, "R10 done without request", 1, 0);
        else begin
          chk(busy_cyc == (q[0].ext ? 9 : 7), "R7 access length", busy_cyc, q[0].ext ? 9 : 7);
          chk(bus_hi == q[0].addr[11:8], "R1 upper address held", bus_hi, q[0].addr[11:8]);
          if (!q[0].wr) chk(rdata == q[0].data, "R6 read data", rdata, q[0].data);
          void'(q.pop_front());
        end
        busy_cyc = 0;
      end
      if (prev_as == 1 && done) ; 
      prev_as = as_n; prev_ds = ds_n; prev_oe = ad_oe;
    end
  end

  logic prev_done = 0;
  always @(negedge clk) begin
    if (!rst && !mute && prev_done) chk(!done, "R10 done single cycle", done, 0);
    prev_done = done;
  end

  task automatic poke_busy();
    @(negedge clk);
    while (req_ready) @(negedge clk);
    chk(!req_ready, "R9 not ready while busy", req_ready, 0);
    req_valid = 1; req_addr = 12'h555; req_write = 0;
    repeat (3) @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      ext_mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(as_n && ds_n && !ad_oe && req_ready && !done, "R11 reset state", {as_n, ds_n, ad_oe, req_ready}, 4'b1101);
    issue(1, 1, 0, 12'h123, 8'hA5);
    issue(1, 0, 1, 12'hABC, 8'h3C);
    issue(0, 1, 0, 12'h123, 8'h00);
    issue(0, 0, 1, 12'hABC, 8'h00);
    issue(0, 1, 0, 12'h0FF, 8'h00);
    issue(1, 0, 0, 12'hF00, 8'h00);
    issue(1, 1, 1, 12'h801, 8'hFF);
    fork
      issue(0, 0, 0, 12'hF00, 8'h00);
      poke_busy();
    join
    issue(0, 1, 1, 12'h801, 8'h00);
    issue(0, 0, 0, 12'hFFF, 8'h00);
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(started == issued, "R9 busy request ignored", started, issued);
    mute = 1;
    req_valid = 1; req_write = 1; req_addr = 12'h777; req_wdata = 8'h11;
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk(as_n && ds_n && !ad_oe && req_ready, "R11 reset mid-access", {as_n, ds_n, ad_oe, req_ready}, 4'b1101);
    @(negedge clk);
    chk(as_n && ds_n && !ad_oe && req_ready, "R11 idle after reset", {as_n, ds_n, ad_oe, req_ready}, 4'b1101);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule